// File: doc/BRIEF.md
# Global History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register that holds the outcomes of the most recent resolved branches. It also keeps a table of 2-bit saturating counters. To choose a counter, the block mixes the history with low bits of the branch address. A parameter sets how they are mixed: the history can be placed beside the address bits (concatenation), or it can be XORed into them. With concatenation, one branch address selects among a group of counters, one counter for each history pattern.

The fetch side presents an address on the prediction port and reads the taken/not-taken guess in the same cycle, because the read is combinational. When a branch resolves, the execute side presents its address and its actual outcome on the update port. At the next clock edge, exactly one counter changes: the one chosen by that address and the history as it stood before the edge. On the same edge the outcome is shifted into the history. A second update is only counted after the next edge.

Top module: `ghp_predictor`

## Requirements
- R1: After reset every counter holds weakly not taken (01) and the history is all zeros, so every address is predicted not taken.
- R2: The prediction is the upper bit of the selected counter: 11 and 10 give taken (1), 01 and 00 give not taken (0).
- R3: An update with outcome taken (1) raises the selected counter by one, saturating at 11. An update with outcome not taken (0) lowers it by one, saturating at 00.
- R4: A counter that has reached a strong state (00 or 11) changes the predicted direction only after two updates against it.
- R5: Each update shifts its outcome into history bit 0, with 1 for taken. Older bits move one place up and the oldest bit is dropped.
- R6: In XOR mode (MODE=1) the counter index is upd/pred address bits [PC_LSB+IDX_W-1:PC_LSB] XOR the zero-extended history.
- R7: In concatenation mode (MODE=0) the counter index is {history, address bits [PC_LSB+IDX_W-HIST_W-1:PC_LSB]}, with the history in the upper bits.
- R8: An update computes its index from the history as it was before that update's shift, and it changes no counter other than the indexed one.
- R9: While upd_valid is low, neither the counters nor the history change, whatever upd_pc and upd_taken carry.
- R10: The prediction follows pred_pc within the same cycle. An update presented in that cycle becomes visible only after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronised inside the block |
| pred_pc | input | PC_W | Address of the branch to be predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A counter that steps the wrong way or fails to saturate shows up on pred_taken the next time its index is read. The bench forces that read within one or two cycles of the update, by choosing addresses whose index, XORed with the newly shifted history, lands back on the same entry. A history that shifts wrongly, or an update indexed with the post-shift history, moves every later read onto another entry. A reference table in the bench therefore sees a disagreement within a few updates. Updates that hit a neighbouring entry stay hidden until that entry is predicted, so the bench predicts every address it has trained, in both index modes.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  typedef enum logic {
    IDX_CONCAT = 1'b0,
    IDX_XOR    = 1'b1
  } idx_mode_e;

  // one saturating step of a direction counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/ghp_rst_sync.sv
module ghp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/ghp_history.sv
module ghp_history #(
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_q
);

  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      always_comb hist_d = shift_bit;
    end else begin : g_many
      always_comb hist_d = {hist_q[HIST_W-2:0], shift_bit};
    end
  endgenerate

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

endmodule

// File: rtl/ghp_index.sv
module ghp_index #(
  parameter int unsigned       PC_W   = 32,
  parameter int unsigned       HIST_W = 4,
  parameter int unsigned       IDX_W  = 8,
  parameter int unsigned       PC_LSB = 2,
  parameter ghp_pkg::idx_mode_e MODE  = ghp_pkg::IDX_XOR
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned PAD_W = IDX_W - HIST_W;

  generate
    if (MODE == ghp_pkg::IDX_CONCAT) begin : g_cat
      assign idx = {hist, pc[PC_LSB +: PAD_W]};
      logic unused_pc;
      assign unused_pc = ^{pc};
    end else begin : g_xor
      assign idx = pc[PC_LSB +: IDX_W] ^ {{PAD_W{1'b0}}, hist};
      logic unused_pc;
      assign unused_pc = ^{pc};
    end
  endgenerate

endmodule

// File: rtl/ghp_table.sv
module ghp_table #(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 srst_n,
  input  logic [IDX_W-1:0]     rd_idx,
  output ghp_pkg::ctr_t        rd_ctr,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_taken,
  output logic [2*DEPTH-1:0]   ctr_flat
);

  import ghp_pkg::*;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      ctr_t q;
      ctr_t d;
      logic hit;

      always_comb begin
        hit = wr_en && (wr_idx == IDX_W'(e));
        d   = hit ? ctr_step(q, wr_taken) : q;
      end

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n)  q <= CTR_WNT;
        else if (hit) q <= d;
      end

      assign ctr_flat[2*e +: 2] = q;
    end
  endgenerate

  always_comb rd_ctr = ctr_t'(ctr_flat[{rd_idx, 1'b0} +: 2]);

endmodule

// File: rtl/ghp_predictor.sv
module ghp_predictor #(
  parameter int unsigned        PC_W   = 32,
  parameter int unsigned        HIST_W = 4,
  parameter int unsigned        IDX_W  = 8,
  parameter int unsigned        PC_LSB = 2,
  parameter ghp_pkg::idx_mode_e MODE   = ghp_pkg::IDX_XOR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  import ghp_pkg::*;

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic               srst_n;
  logic [HIST_W-1:0]  hist_q;
  logic [IDX_W-1:0]   pred_idx;
  logic [IDX_W-1:0]   upd_idx;
  ctr_t               rd_ctr;
  logic [2*DEPTH-1:0] ctr_flat;

  ghp_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ghp_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .srst_n    (srst_n),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist_q    (hist_q)
  );

  ghp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB), .MODE(MODE)) u_pidx (
    .pc   (pred_pc),
    .hist (hist_q),
    .idx  (pred_idx)
  );

  // update index uses the history before this update shifts it
  ghp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB), .MODE(MODE)) u_uidx (
    .pc   (upd_pc),
    .hist (hist_q),
    .idx  (upd_idx)
  );

  ghp_table #(.IDX_W(IDX_W)) u_tab (
    .clk      (clk),
    .srst_n   (srst_n),
    .rd_idx   (pred_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken),
    .ctr_flat (ctr_flat)
  );

  assign pred_taken = ctr_dir(rd_ctr);

endmodule

// File: rtl/ghp_predictor_chk.sv
module ghp_predictor_chk #(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input logic               clk,
  input logic               srst_n,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [IDX_W-1:0]   upd_idx,
  input logic [HIST_W-1:0]  hist_q,
  input logic [2*DEPTH-1:0] ctr_flat
);

  logic [1:0]         cur;
  logic [IDX_W-1:0]   idx_q;
  logic [1:0]         val_at_q;
  logic [2*DEPTH-1:0] prev_flat;
  logic [DEPTH-1:0]   chg;

  always_ff @(posedge clk) begin
    idx_q     <= upd_idx;
    prev_flat <= ctr_flat;
  end

  assign cur      = ctr_flat[{upd_idx, 1'b0} +: 2];
  assign val_at_q = ctr_flat[{idx_q, 1'b0} +: 2];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_chg
      assign chg[e] = ctr_flat[2*e +: 2] != prev_flat[2*e +: 2];
    end
  endgenerate

  AST_INC_ON_TAKEN: assert property (@(posedge clk) disable iff (!srst_n)
    (upd_valid && upd_taken && cur != 2'b11) |=> val_at_q == $past(cur) + 2'd1); // R3
  AST_DEC_ON_NOT_TAKEN: assert property (@(posedge clk) disable iff (!srst_n)
    (upd_valid && !upd_taken && cur != 2'b00) |=> val_at_q == $past(cur) - 2'd1); // R3
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!srst_n)
    (upd_valid && upd_taken && cur == 2'b11) |=> val_at_q == 2'b11); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!srst_n)
    (upd_valid && !upd_taken && cur == 2'b00) |=> val_at_q == 2'b00); // R3
  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!srst_n)
    upd_valid |=> hist_q[0] == $past(upd_taken)); // R5
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !upd_valid |=> $stable(hist_q)); // R9
  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !upd_valid |=> $stable(ctr_flat)); // R9
  AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(chg) <= 1); // R8

endmodule

bind ghp_predictor ghp_predictor_chk #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .upd_valid (upd_valid),
  .upd_taken (upd_taken),
  .upd_idx   (upd_idx),
  .hist_q    (hist_q),
  .ctr_flat  (ctr_flat)
);

// File: tb/sim_ghp_predictor.sv
module sim_ghp_predictor;

  localparam int unsigned PC_W = 32;
  localparam int unsigned NVEC = 16;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] pred_pc;
  logic            p_x;
  logic            p_s;
  logic            upd_valid;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken;

  int n_chk;
  int n_err;

  // reference state: XOR-mode table, concatenation-mode table, history
  logic [1:0] m_x [256];
  logic [1:0] m_s [256];
  logic [3:0] m_h;

  // vector: {taken, pc}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0044},
    {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0044},
    {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0100},
    {1'b0, 32'h0000_0044}, {1'b0, 32'h0000_0044}, {1'b1, 32'h0000_0148},
    {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0100}, {1'b1, 32'h0000_0148},
    {1'b1, 32'h0000_0044}
  };

  ghp_predictor #(.MODE(ghp_pkg::IDX_XOR)) u0 (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(p_x),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  ghp_predictor #(.MODE(ghp_pkg::IDX_CONCAT)) u1 (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(p_s),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] ix(input logic [PC_W-1:0] pc, input logic [3:0] h);
    return pc[9:2] ^ {4'b0000, h};   // R6
  endfunction

  function automatic logic [7:0] is(input logic [PC_W-1:0] pc, input logic [3:0] h);
    return {h, pc[5:2]};             // R7
  endfunction

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_x[i] = 2'b01;
      m_s[i] = 2'b01;
    end
    m_h = 4'h0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  // called in the low phase; samples before the next rising edge
  task automatic pred_both(input logic [PC_W-1:0] pc, input string req);
    pred_pc = pc;
    #3;
    chk({req, " xor"},    p_x, m_x[ix(pc, m_h)][1]);
    chk({req, " concat"}, p_s, m_s[is(pc, m_h)][1]);
  endtask

  task automatic pred_x(input logic [PC_W-1:0] pc, input logic exp, input string req);
    pred_pc = pc;
    #3;
    chk(req, p_x, exp);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic t);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_pc    = pc;
    upd_taken = t;
    @(posedge clk);
    m_x[ix(pc, m_h)] = sat(m_x[ix(pc, m_h)], t);   // R8: index from old history
    m_s[is(pc, m_h)] = sat(m_s[is(pc, m_h)], t);
    m_h = {m_h[2:0], t};                            // R5
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    #4000000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    pred_pc = '0;
    upd_valid = 1'b0;
    upd_pc = '0;
    upd_taken = 1'b0;
    model_reset();
    do_reset();

    // R1: reset state, everything not taken
    for (int i = 0; i < 8; i++) pred_both(32'(i * 132), "R1 reset");

    // table walk: predict each branch, then resolve it (R2, R5, R6, R7, R8)
    for (int v = 0; v < NVEC; v++) begin
      pred_both(VEC[v][31:0], "R2 R6 R7 walk");
      upd(VEC[v][31:0], VEC[v][32]);
    end
    for (int v = 0; v < NVEC; v++) pred_both(VEC[v][31:0], "R8 R5 trained");

    // R1: reset clears training
    do_reset();
    for (int v = 0; v < 4; v++) pred_both(VEC[v][31:0], "R1 after retrain reset");

    // R3 floor and R4 from strong not taken, index 0x20 reused via history
    repeat (3) upd(32'h080, 1'b0);
    pred_x(32'h080, 1'b0, "R3 floor");
    upd(32'h080, 1'b1);
    pred_x(32'h084, 1'b0, "R4 one miss from strong nt");
    upd(32'h084, 1'b1);
    pred_x(32'h08C, 1'b1, "R4 two misses flip");
    pred_both(32'h08C, "R4 model");

    // R3 ceiling and R4 from strong taken, index 0x4F under history 1111
    do_reset();
    repeat (8) upd(32'h100, 1'b1);
    pred_x(32'h100, 1'b1, "R3 ceiling");
    upd(32'h100, 1'b0);
    pred_x(32'h104, 1'b1, "R4 one miss from strong t");
    upd(32'h104, 1'b0);
    pred_x(32'h10C, 1'b0, "R4 two misses flip");

    // R10: update in the same cycle as a read of the same entry
    @(negedge clk);
    pred_pc   = 32'h10C;
    upd_valid = 1'b1;
    upd_pc    = 32'h10C;
    upd_taken = 1'b1;
    #3;
    chk("R10 old value before edge", p_x, 1'b0);
    @(posedge clk);
    m_x[ix(32'h10C, m_h)] = sat(m_x[ix(32'h10C, m_h)], 1'b1);
    m_s[is(32'h10C, m_h)] = sat(m_s[is(32'h10C, m_h)], 1'b1);
    m_h = {m_h[2:0], 1'b1};
    @(negedge clk);
    upd_valid = 1'b0;
    pred_x(32'h118, 1'b1, "R10 new value after edge");

    // R9: idle update port with toggling data changes nothing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      upd_pc    = 32'h118;
      upd_taken = i[0];
    end
    pred_x(32'h118, 1'b1, "R9 idle keeps entry and history");
    pred_both(32'h118, "R9 model");
    pred_both(32'h10C, "R9 model other");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule